// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control side of an eight-input, 12-bit successive-approximation converter. Software programs one control word through a small register port. The word holds the enabled-channel mask, a clock divisor, a continuous-scan enable, a power enable, a three-bit start code and a trigger polarity. The block then runs the converter. It produces a divided converter clock enable, a channel select, and a one-cycle start request. It captures the 12-bit sample that the converter returns with a ready pulse, and it presents that sample in a data word together with its channel number, an overrun flag and a done flag.

A state machine with four states controls the sequencing. `ST_OFF` holds the converter inactive while the power bit is clear. `ST_IDLE` waits for a start. `ST_LAUNCH` drives the start request for one cycle. `ST_WAIT` waits for the converter's ready pulse.

The transitions are:
- Any control write with power clear goes to `ST_OFF`.
- A control write with power set goes to `ST_LAUNCH` when a conversion was in flight, when scanning is enabled, or when the start code is the immediate code. Any other control write with power set goes to `ST_IDLE`.
- `ST_IDLE` goes to `ST_LAUNCH` on a qualified trigger edge.
- `ST_LAUNCH` always goes to `ST_WAIT`.
- On the ready pulse, `ST_WAIT` goes back to `ST_LAUNCH` with the next channel when scanning, and to `ST_IDLE` otherwise.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Address 0 reads back the control word with bits 31:22 zero. The fields are: mask at bits 7:0, divisor at 15:8, scan enable at 16, power at 17, start code at 20:18 and trigger polarity at 21.
- R2: While powered, `conv_clk_en` pulses once every divisor+1 cycles. A control write restarts the divider phase at zero.
- R3: While the power bit is 0, `conv_req` and `conv_clk_en` stay low. A control write with power 0 abandons any conversion.
- R4: An all-zero channel mask behaves as if only channel 0 were enabled.
- R5: With scanning off, start code 000 issues no request. Start code 001 issues exactly one `conv_req` in the cycle after the control write, on the lowest enabled channel.
- R6: With scanning off, start codes 010 to 111 select `trig_in[code-2]`. Polarity 1 means a rising edge starts a conversion and polarity 0 means a falling edge. Each qualifying edge, after a two-flop synchronizer, gives exactly one request. Opposite edges and unselected inputs give none.
- R7: With scanning on, requests follow ascending enabled channel order and wrap from the highest enabled channel to the lowest. Each new request comes in the cycle after a result is accepted. A control write that clears scanning stops further requests once the restarted conversion completes.
- R8: Address 1 reads the data word: done at bit 31, overrun at bit 30, channel at bits 26:24, result at bits 15:4, and all other bits zero.
- R9: Done is set when a result is accepted. Done is cleared by a read strobe at address 1 or by a control write. A result accepted in the same cycle as a read leaves done set.
- R10: A control write while a conversion is in flight (`ST_LAUNCH` or `ST_WAIT`) with power set does three things. It forces done to 1, drops the pending result, and issues a fresh request in the next cycle on the lowest channel of the new mask.
- R11: When a result is accepted in scan mode, overrun becomes 1 if the previous result was still unread (done set and not read that cycle), and 0 otherwise. In single mode overrun becomes 0.
- R12: A `conv_rdy` pulse outside `ST_WAIT` leaves the data word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe; writes the control word when bus_addr is 0 |
| bus_rd | input | 1 | Read strobe; a read at address 1 clears done |
| bus_addr | input | 1 | 0 selects the control word, 1 the data word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected address (combinational) |
| trig_in | input | 6 | External asynchronous trigger inputs |
| conv_clk_en | output | 1 | Converter clock enable, one pulse per divided period |
| conv_chan | output | 3 | Channel select for the converter |
| conv_req | output | 1 | One-cycle start-of-conversion strobe |
| conv_rdy | input | 1 | Converter result valid pulse |
| conv_result | input | 12 | Converter sample |

## Verification
The bench targets these corner cases and the failure each one exposes:
- Sparse masks whose scan must skip holes and wrap. A wrong next-channel search repeats a channel or stalls on the highest one.
- A control write that lands while a scan is mid-conversion. A design that only clears done would leave done at 0 and send no fresh request.
- Unread results in scan mode. A design that compares against the wrong cycle's done either never reports overrun or still reports it after software has read the word.
- Opposite-polarity and unselected trigger edges, plus stray converter ready pulses in idle or power-down. A loose design would start conversions or overwrite the captured result.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int N_CH    = 8;
    localparam int CH_W    = $clog2(N_CH);
    localparam int RES_W   = 12;
    localparam int DIV_W   = 8;
    localparam int START_W = 3;
    localparam int N_TRIG  = (1 << START_W) - 2;
    localparam int WORD_W  = 32;

    // Start codes with fixed meaning; codes 2 and up select a trigger input
    localparam logic [START_W-1:0] START_IDLE = '0;
    localparam logic [START_W-1:0] START_NOW  = START_W'(1);

    // Data word bit positions
    localparam int DW_DONE  = 31;
    localparam int DW_OVR   = 30;
    localparam int DW_CH_LO = 24;
    localparam int DW_RS_LO = 4;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT
    } seq_state_t;

    // Packed so that mask lands at bit 0 and polarity on top
    typedef struct packed {
        logic               rise;
        logic [START_W-1:0] start;
        logic               pwr;
        logic               scan;
        logic [DIV_W-1:0]   div;
        logic [N_CH-1:0]    mask;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             at_end;

    assign at_end = (cnt_q == div);
    assign tick   = run && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !run || at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n) (tick && (div != '0) && !clr) |=> !tick); // R2

endmodule

// File: rtl/adc_seq_chsel.sv
module adc_seq_chsel #(
    parameter int N_CH = 8,
    parameter int CH_W = $clog2(N_CH)
) (
    input  logic [N_CH-1:0] mask,
    input  logic [CH_W-1:0] cur,
    output logic [N_CH-1:0] eff,
    output logic [CH_W-1:0] first,
    output logic [CH_W-1:0] next
);

    // Empty mask stands for channel 0 alone
    assign eff = (mask == '0) ? N_CH'(1) : mask;

    always_comb begin
        first = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (eff[i]) begin
                first = CH_W'(i);
            end
        end
    end

    // Lowest enabled channel above cur, else wrap to the lowest overall
    always_comb begin
        next = first;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (eff[i] && (i > int'(cur))) begin
                next = CH_W'(i);
            end
        end
    end

endmodule

// File: rtl/adc_seq_trig.sv
module adc_seq_trig #(
    parameter int N_TRIG  = 6,
    parameter int START_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_TRIG-1:0]  trig_in,
    input  logic [START_W-1:0] code,
    input  logic               rise,
    output logic               hit
);

    logic [N_TRIG-1:0] meta_q, sync_q, last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            last_q <= '0;
        end else begin
            meta_q <= trig_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < N_TRIG; i++) begin
            if (int'(code) == i + 2) begin
                hit = rise ? (sync_q[i] && !last_q[i]) : (!sync_q[i] && last_q[i]);
            end
        end
    end

    AST_HIT_CODE: assert property (@(posedge clk) disable iff (!rst_n) hit |-> (int'(code) >= 2)); // R6

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic                bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [N_TRIG-1:0]   trig_in,
    output logic                conv_clk_en,
    output logic [CH_W-1:0]     conv_chan,
    output logic                conv_req,
    input  logic                conv_rdy,
    input  logic [RES_W-1:0]    conv_result
);

    ctrl_t      ctrl_q, ctrl_new;
    seq_state_t state_q, state_d;
    logic [CH_W-1:0]  chan_q, chan_d;
    logic [RES_W-1:0] res_q;
    logic [CH_W-1:0]  rchan_q;
    logic             done_q, ovr_q;

    logic ctrl_wr, data_rd, busy, accept, trig_hit;
    logic [N_CH-1:0] eff_cur;
    logic [CH_W-1:0] first_cur, next_cur, first_new;
    logic [N_CH-1:0] unused_eff_new;
    logic [CH_W-1:0] unused_next_new;
    logic            unused_wdata;

    assign ctrl_wr      = bus_wr && (bus_addr == 1'b0);
    assign data_rd      = bus_rd && (bus_addr == 1'b1);
    assign ctrl_new     = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    assign unused_wdata = ^bus_wdata[WORD_W-1:CTRL_W];
    assign busy         = (state_q == ST_LAUNCH) || (state_q == ST_WAIT);
    assign accept       = (state_q == ST_WAIT) && conv_rdy && !ctrl_wr;

    adc_seq_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (ctrl_q.pwr),
        .clr  (ctrl_wr),
        .div  (ctrl_q.div),
        .tick (conv_clk_en)
    );

    adc_seq_chsel #(.N_CH(N_CH), .CH_W(CH_W)) u_sel_cur (
        .mask (ctrl_q.mask),
        .cur  (chan_q),
        .eff  (eff_cur),
        .first(first_cur),
        .next (next_cur)
    );

    adc_seq_chsel #(.N_CH(N_CH), .CH_W(CH_W)) u_sel_new (
        .mask (ctrl_new.mask),
        .cur  (chan_q),
        .eff  (unused_eff_new),
        .first(first_new),
        .next (unused_next_new)
    );

    adc_seq_trig #(.N_TRIG(N_TRIG), .START_W(START_W)) u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_in(trig_in),
        .code   (ctrl_q.start),
        .rise   (ctrl_q.rise),
        .hit    (trig_hit)
    );

    // Next state and channel
    always_comb begin
        state_d = state_q;
        chan_d  = chan_q;
        if (ctrl_wr) begin
            if (!ctrl_new.pwr) begin
                state_d = ST_OFF;
            end else if (busy || ctrl_new.scan || (ctrl_new.start == START_NOW)) begin
                state_d = ST_LAUNCH;
                chan_d  = first_new;
            end else begin
                state_d = ST_IDLE;
            end
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_OFF;
                end
                ST_IDLE: begin
                    if (!ctrl_q.scan && trig_hit) begin
                        state_d = ST_LAUNCH;
                        chan_d  = first_cur;
                    end
                end
                ST_LAUNCH: begin
                    state_d = ST_WAIT;
                end
                ST_WAIT: begin
                    if (conv_rdy) begin
                        if (ctrl_q.scan) begin
                            state_d = ST_LAUNCH;
                            chan_d  = next_cur;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            chan_q  <= '0;
        end else begin
            state_q <= state_d;
            chan_q  <= chan_d;
        end
    end

    // Control and captured result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            res_q   <= '0;
            rchan_q <= '0;
            done_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q <= ctrl_new;
                done_q <= busy;
            end else if (accept) begin
                res_q   <= conv_result;
                rchan_q <= chan_q;
                ovr_q   <= ctrl_q.scan && done_q && !data_rd;
                done_q  <= 1'b1;
            end else if (data_rd) begin
                done_q <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        conv_req  = (state_q == ST_LAUNCH);
        conv_chan = chan_q;
        if (bus_addr) begin
            bus_rdata = '0;
            bus_rdata[DW_DONE] = done_q;
            bus_rdata[DW_OVR]  = ovr_q;
            bus_rdata[DW_CH_LO +: CH_W]  = rchan_q;
            bus_rdata[DW_RS_LO +: RES_W] = res_q;
        end else begin
            bus_rdata = WORD_W'(ctrl_q);
        end
    end

    AST_OFF_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) !ctrl_q.pwr |-> (!conv_req && !conv_clk_en)); // R3
    AST_REQ_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n) (conv_req && !ctrl_wr) |=> !conv_req); // R5
    AST_REQ_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n) conv_req |-> eff_cur[conv_chan]); // R7
    AST_DONE_SET:    assert property (@(posedge clk) disable iff (!rst_n) accept |=> done_q); // R9
    AST_READ_CLR:    assert property (@(posedge clk) disable iff (!rst_n) (data_rd && !accept && !ctrl_wr) |=> !done_q); // R9
    AST_WR_RESTART:  assert property (@(posedge clk) disable iff (!rst_n) (ctrl_wr && busy && ctrl_new.pwr) |=> (conv_req && done_q)); // R10
    AST_OVR_SCAN:    assert property (@(posedge clk) disable iff (!rst_n) $rose(ovr_q) |-> $past(ctrl_q.scan)); // R11
    AST_STRAY_RDY:   assert property (@(posedge clk) disable iff (!rst_n) (conv_rdy && (state_q != ST_WAIT) && !ctrl_wr) |=> $stable(res_q)); // R12

endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;

    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b1;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  trig_in = '0;
    logic        conv_clk_en, conv_req;
    logic [2:0]  conv_chan;
    logic        conv_rdy = 1'b0;
    logic [11:0] conv_result = '0;

    always #5 clk = ~clk;

    adc_seq_ctrl u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig_in(trig_in), .conv_clk_en(conv_clk_en), .conv_chan(conv_chan),
        .conv_req(conv_req), .conv_rdy(conv_rdy), .conv_result(conv_result)
    );

    int n_cmp = 0, n_bad = 0;
    int cd = 0, res_seq = 0, n_req = 0, n_en = 0, last_ch = 0;
    bit stray = 0, last_req = 0, done_run = 0;
    logic [31:0] last_rdata;
    int req_log[$];

    // Reference model state
    logic [7:0] m_mask = '0, m_div = '0, m_cnt = '0;
    logic [2:0] m_start = '0;
    bit m_scan = 0, m_pwr = 0, m_rise = 0;
    int m_st = 0, m_ch = 0, m_rch = 0;
    bit m_done = 0, m_ovr = 0;
    logic [11:0] m_res = '0;
    logic [5:0] t1 = '0, t2 = '0, t3 = '0;

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int m_first(logic [7:0] m);
        logic [7:0] e = (m == 8'h00) ? 8'h01 : m;
        for (int j = 0; j < 8; j++) if (e[j]) return j;
        return 0;
    endfunction

    function automatic int m_next(logic [7:0] m, int cur);
        logic [7:0] e = (m == 8'h00) ? 8'h01 : m;
        for (int k = 1; k <= 8; k++) begin
            int j = (cur + k) % 8;
            if (e[j]) return j;
        end
        return cur;
    endfunction

    function automatic logic [31:0] mk(logic [7:0] mask, logic [7:0] div, bit scan, bit pwr, logic [2:0] start, bit rise);
        return {10'b0, rise, start, pwr, scan, div, mask};
    endfunction

    task automatic model_update();
        bit wr = bus_wr && !bus_addr;
        bit rd = bus_rd && bus_addr;
        bit busy = (m_st == 2) || (m_st == 3);
        bit hit = 0;
        bit acc = !wr && (m_st == 3) && conv_rdy;
        if (m_start >= 3'd2) begin
            int idx = int'(m_start) - 2;
            hit = m_rise ? (t2[idx] && !t3[idx]) : (!t2[idx] && t3[idx]);
        end
        if (wr || !m_pwr || m_cnt == m_div) m_cnt = '0; else m_cnt = m_cnt + 8'd1;
        if (wr) begin
            m_mask = bus_wdata[7:0]; m_div = bus_wdata[15:8]; m_scan = bus_wdata[16];
            m_pwr = bus_wdata[17]; m_start = bus_wdata[20:18]; m_rise = bus_wdata[21];
            m_done = busy;
            if (!m_pwr) m_st = 0;
            else if (busy || m_scan || m_start == 3'd1) begin m_st = 2; m_ch = m_first(m_mask); end
            else m_st = 1;
        end else if (m_st == 1 && !m_scan && hit) begin
            m_st = 2; m_ch = m_first(m_mask);
        end else if (m_st == 2) begin
            m_st = 3;
        end else if (acc) begin
            m_res = conv_result; m_rch = m_ch;
            m_ovr = m_scan && m_done && !rd;
            m_done = 1;
            if (m_scan) begin m_st = 2; m_ch = m_next(m_mask, m_ch); end
            else m_st = 1;
        end
        if (!wr && !acc && rd) m_done = 0;
        t3 = t2; t2 = t1; t1 = trig_in;
    endtask

    task automatic cycle();
        logic [31:0] exp_rd;
        bit exp_en;
        if (stray) begin
            conv_rdy = 1; conv_result = 12'hABC; stray = 0;
        end else if (cd == 1) begin
            cd = 0; conv_rdy = 1; conv_result = 12'(res_seq * 113 + 7); res_seq++;
        end else begin
            conv_rdy = 0; if (cd > 1) cd--;
        end
        #1;
        exp_en = m_pwr && (m_cnt == m_div);
        exp_rd = bus_addr ? {m_done, m_ovr, 3'b0, 3'(m_rch), 8'b0, m_res, 4'b0}
                          : mk(m_mask, m_div, m_scan, m_pwr, m_start, m_rise);
        chk(conv_clk_en === exp_en, "R2 clk_en", 32'(conv_clk_en), 32'(exp_en));
        chk(conv_req === (m_st == 2), "R5 req", 32'(conv_req), 32'(m_st == 2));
        chk(conv_chan === 3'(m_ch), "R7 chan", 32'(conv_chan), 32'(m_ch));
        chk(bus_rdata === exp_rd, "R8 rdata", bus_rdata, exp_rd);
        last_rdata = bus_rdata;
        last_req = conv_req;
        if (conv_req) begin cd = LAT; n_req++; last_ch = int'(conv_chan); req_log.push_back(last_ch); end
        if (conv_clk_en) n_en++;
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle_n(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic wr_ctrl(logic [31:0] v);
        bus_wr = 1; bus_addr = 0; bus_wdata = v;
        cycle();
        bus_wr = 0; bus_addr = 1;
    endtask

    task automatic rd_data(output logic [31:0] v);
        bus_rd = 1; bus_addr = 1;
        cycle();
        bus_rd = 0;
        v = last_rdata;
    endtask

    initial begin
        logic [31:0] v, v0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // Reset state
        #1;
        chk(bus_rdata == 32'h0, "R8 reset data", bus_rdata, 32'h0);
        chk(!conv_req && !conv_clk_en, "R3 reset quiet", {conv_req, conv_clk_en}, 0);
        @(negedge clk);

        // R1 control readback
        wr_ctrl(mk(8'hA5, 8'd3, 0, 1, 3'd0, 0));
        bus_addr = 0; cycle(); bus_addr = 1;
        chk(last_rdata == 32'h000203A5, "R1 readback", last_rdata, 32'h000203A5);

        // R2 divider, R5 no start with code 000
        n_en = 0; n_req = 0; idle_n(40);
        chk(n_en == 10, "R2 div3 pulses", n_en, 10);
        wr_ctrl(mk(8'hA5, 8'd0, 0, 1, 3'd0, 0));
        n_en = 0; idle_n(20);
        chk(n_en == 20, "R2 div0 pulses", n_en, 20);
        chk(n_req == 0, "R5 code 000", n_req, 0);

        // R5 immediate start, R9 done handling
        n_req = 0;
        wr_ctrl(mk(8'h28, 8'd1, 0, 1, 3'd1, 0));
        idle_n(12);
        chk(n_req == 1, "R5 one request", n_req, 1);
        chk(last_ch == 3, "R5 lowest channel", last_ch, 3);
        rd_data(v);
        chk(v[31] == 1'b1, "R9 done set", v, 32'h80000000);
        chk(v[26:24] == 3'd3, "R8 channel field", 32'(v[26:24]), 3);
        chk(v[15:4] == 12'((res_seq - 1) * 113 + 7), "R8 result field", 32'(v[15:4]), 32'((res_seq - 1) * 113 + 7));
        chk(v[30] == 1'b0, "R11 single no overrun", 32'(v[30]), 0);
        rd_data(v);
        chk(v[31] == 1'b0, "R9 read clears", 32'(v[31]), 0);

        // R4 empty mask
        n_req = 0;
        wr_ctrl(mk(8'h00, 8'd0, 0, 1, 3'd1, 0));
        idle_n(12);
        chk(n_req == 1 && last_ch == 0, "R4 empty mask", last_ch, 0);

        // R6 trigger edges on trig_in[1] (code 3)
        wr_ctrl(mk(8'h30, 8'd1, 0, 1, 3'd3, 1));
        idle_n(4);
        n_req = 0; trig_in[1] = 1; idle_n(12);
        chk(n_req == 1 && last_ch == 4, "R6 rising start", n_req, 1);
        n_req = 0; trig_in[1] = 0; trig_in[0] = 1; idle_n(12);
        chk(n_req == 0, "R6 falling/unselected ignored", n_req, 0);
        trig_in[0] = 0;
        wr_ctrl(mk(8'h30, 8'd1, 0, 1, 3'd3, 0));
        n_req = 0; trig_in[1] = 1; idle_n(8);
        chk(n_req == 0, "R6 rising ignored", n_req, 0);
        trig_in[1] = 0; idle_n(12);
        chk(n_req == 1, "R6 falling start", n_req, 1);

        // R7 scan order, R11 overrun
        rd_data(v);
        req_log.delete();
        wr_ctrl(mk(8'h92, 8'd0, 1, 1, 3'd0, 0));
        for (int i = 0; i < 40 && req_log.size() < 5; i++) cycle();
        chk(req_log.size() >= 5 && req_log[0] == 1 && req_log[1] == 4 && req_log[2] == 7
            && req_log[3] == 1 && req_log[4] == 4, "R7 scan order", req_log.size(), 5);
        cycle();
        chk(last_rdata[30] == 1'b1, "R11 overrun set", last_rdata, 32'hC0000000);
        rd_data(v);
        for (int i = 0; i < 12; i++) begin
            cycle();
            if (last_rdata[31]) break;
        end
        chk(last_rdata[31] && !last_rdata[30], "R11 overrun clears after read", last_rdata[31:30], 2'b10);

        // R10 write while converting, R7 scan stops
        wr_ctrl(mk(8'h40, 8'd0, 0, 1, 3'd0, 0));
        cycle();
        chk(last_req == 1 && last_ch == 6, "R10 fresh request", last_ch, 6);
        chk(last_rdata[31] == 1'b1, "R10 done forced", last_rdata, 32'h80000000);
        idle_n(8);
        n_req = 0; idle_n(20);
        chk(n_req == 0, "R7 scan stopped", n_req, 0);

        // R3 power down
        wr_ctrl(mk(8'hFF, 8'd0, 1, 1, 3'd0, 0));
        idle_n(7);
        wr_ctrl(mk(8'hFF, 8'd0, 1, 0, 3'd0, 0));
        n_req = 0; n_en = 0; idle_n(20);
        chk(n_req == 0 && n_en == 0, "R3 powered down", n_req + n_en, 0);

        // R12 stray ready in idle
        wr_ctrl(mk(8'h01, 8'd0, 0, 1, 3'd0, 0));
        rd_data(v0);
        cycle(); v0 = last_rdata;
        stray = 1; cycle(); idle_n(2);
        chk(last_rdata == v0, "R12 stray ignored", last_rdata, v0);

        done_run = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_run) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule